// File: doc/BRIEF.md
# Segmented Page-Table Walk Unit

This unit turns a 32-bit virtual address into a physical address by walking linear page tables, one per address region. Pages are 512 bytes, so the low nine bits pass through as the byte offset and the upper 23 bits form the virtual page number. The two highest bits of that page number pick one of three regions: two per-process user regions in the lower half of the space and one shared system region in the upper half. Each region has a base register (where its table starts) and a bounds register (how many entries it holds).

The system table sits in physical memory, so a system-region translation costs a single entry read. The user tables sit in system virtual space. A user-region translation therefore first translates the address of its own table entry through the system table, and only then reads the user entry. The unit reads entries over a single-outstanding request/response memory port. It checks the valid bit and the protection level of the final entry, and ends every accepted request with a one-cycle completion pulse that carries either a physical address or a fault code.

A context switch rewrites only the two user regions' base and bounds registers. The system pair stays as it is, so every process sees the same kernel mapping.

Top module: `segpt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `fault` and `paddr` are all 0, and all six base/bounds registers are 0. Any translation then ends with a length fault and no memory read.
- R2: The region code is `req_vaddr[31:30]`: 0 is user region A, 1 is user region B, 2 is the system region. Code 3 ends with fault code 1 (length) and no memory read, and `done` rises on the edge that accepts the request.
- R3: The entry index is `req_vaddr[29:9]`. An index greater than or equal to the region's bounds register ends with a length fault and no memory read.
- R4: A system-region translation issues exactly one read, at system base + 4 × index. When that read is answered (`mem_rvalid` seen on an edge), `done` rises on the same edge.
- R5: A user-region translation computes U = region base + 4 × index. It first reads the system entry at system base + 4 × U[29:9], then reads the user entry at {frame of that system entry, U[8:0]}, zero-extended to 32 bits. Each read is a one-cycle `mem_req` pulse.
- R6: If U[31:30] is not 2, or if U[29:9] is greater than or equal to the system bounds, the user translation ends with a length fault and no memory read.
- R7: An entry with bit 31 (valid) clear ends with fault code 2 (invalid). This applies to both the system entry of a nested lookup and the final entry. On any fault, `paddr` is 0.
- R8: The protection level is entry bits 30:27. The access succeeds only when the level is 3 or less and `req_mode` is no greater than it; otherwise it ends with fault code 3 (protection). Validity is checked before protection. The system entry used in a nested lookup gets no protection check, and the modify bit (26) and the software bits (25:21) are ignored.
- R9: While `busy` is high, `req_valid` and register writes are ignored.
- R10: The register write select encoding is: `reg_sel[2:1]` = region (0, 1, 2), `reg_sel[0]` = 0 for base and 1 for bounds. Selects 6 and 7 have no effect. Rewriting the user-region registers leaves system translations unchanged.
- R11: Every accepted request produces exactly one one-cycle `done` pulse, with fault 0 and `paddr` = {entry bits 20:0, `req_vaddr[8:0]`} on success. Outside the pulse, `fault` and `paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_mode | input | 2 | Access privilege, 0 most privileged |
| busy | output | 1 | Walk in progress |
| reg_wr | input | 1 | Write a base/bounds register |
| reg_sel | input | 3 | Register select: region and base/bounds |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Physical address of the entry read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Completion pulse |
| fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |
| paddr | output | 30 | Translated physical address |

## Verification
A wrong walk state would show up at the memory port before anything else. It would cause a read at an unexpected address, a missing second read for a user region, or a stray read after an immediate fault, and the bench's list of read addresses catches each of these. A wrongly latched offset, mode or frame would show up in `paddr` or `fault` on the completion pulse, about three cycles per read after the request. A stuck or early return to idle would show up as a missing or duplicated `done`, which the bench detects within the same request.

// File: rtl/segpt_pkg.sv
package segpt_pkg;
    localparam int VA_W     = 32;
    localparam int OFS_W    = 9;
    localparam int SEG_W    = 2;
    localparam int IDX_W    = VA_W - OFS_W - SEG_W;
    localparam int PFN_W    = 21;
    localparam int PA_W     = PFN_W + OFS_W;
    localparam int NSEG     = 3;
    localparam int ENT_SH   = 2;
    localparam int SEL_W    = 3;
    localparam int MODE_W   = 2;
    localparam int PROT_W   = 4;
    localparam int PROT_MAX = 3;

    typedef enum logic [SEG_W-1:0] {
        SEG_UA  = 2'd0,
        SEG_UB  = 2'd1,
        SEG_SYS = 2'd2,
        SEG_BAD = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_LEN  = 2'd1,
        FLT_INV  = 2'd2,
        FLT_PROT = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WSYS = 2'd1,
        ST_WFIN = 2'd2
    } st_e;

    typedef struct packed {
        logic              valid;
        logic [PROT_W-1:0] prot;
        logic              modify;
        logic [4:0]        sw;
        logic [PFN_W-1:0]  pfn;
    } pte_t;

    typedef struct packed {
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] bound;
    } segreg_t;

    function automatic logic access_ok(input logic [PROT_W-1:0] prot,
                                       input logic [MODE_W-1:0] mode);
        return (prot <= PROT_W'(PROT_MAX)) && (PROT_W'(mode) <= prot);
    endfunction

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return base + (VA_W'(idx) << ENT_SH);
    endfunction
endpackage

// File: rtl/segpt_regs.sv
module segpt_regs
    import segpt_pkg::*;
#(
    parameter int N = NSEG
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [VA_W-1:0]       wr_data,
    output segreg_t [N-1:0]       regs_o
);
    for (genvar g = 0; g < N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[g] <= '0;
            end else if (wr_en && (wr_sel[SEL_W-1:1] == (SEL_W-1)'(g))) begin
                if (wr_sel[0]) regs_o[g].bound <= wr_data;
                else           regs_o[g].base  <= wr_data;
            end
        end
    end
endmodule

// File: rtl/segpt_segchk.sv
module segpt_segchk
    import segpt_pkg::*;
#(
    parameter int N = NSEG
) (
    input  logic [VA_W-1:0]  va_i,
    input  segreg_t [N-1:0]  regs_i,
    output seg_e             seg_o,
    output logic             in_bounds_o,
    output logic             user_o,
    output logic [VA_W-1:0]  ent_addr_o
);
    logic [IDX_W-1:0] idx;
    segreg_t          sel;

    assign seg_o = seg_e'(va_i[VA_W-1 -: SEG_W]);
    assign idx   = va_i[OFS_W +: IDX_W];

    always_comb begin
        sel = '0;
        for (int s = 0; s < N; s++) begin
            if (va_i[VA_W-1 -: SEG_W] == SEG_W'(s)) sel = regs_i[s];
        end
    end

    assign in_bounds_o = (seg_o != SEG_BAD) && (VA_W'(idx) < sel.bound);
    assign user_o      = (seg_o == SEG_UA) || (seg_o == SEG_UB);
    assign ent_addr_o  = entry_addr(sel.base, idx);
endmodule

// File: rtl/segpt_pte_eval.sv
module segpt_pte_eval
    import segpt_pkg::*;
(
    input  logic [VA_W-1:0]    ent_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               chk_prot_i,
    output fault_e             fault_o,
    output logic [PFN_W-1:0]   pfn_o
);
    pte_t p;
    assign p     = pte_t'(ent_i);
    assign pfn_o = p.pfn;

    always_comb begin
        if (!p.valid)                                 fault_o = FLT_INV;
        else if (chk_prot_i && !access_ok(p.prot, mode_i)) fault_o = FLT_PROT;
        else                                          fault_o = FLT_NONE;
    end
endmodule

// File: rtl/segpt_walker.sv
module segpt_walker
    import segpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_mode,
    output logic              busy,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [1:0]        fault,
    output logic [29:0]       paddr
);
    st_e               state;
    segreg_t [NSEG-1:0] regs;

    seg_e              v_seg, n_seg;
    logic              v_inb, v_user, n_inb, n_user;
    logic [VA_W-1:0]   v_ent, n_ent;
    fault_e            e_fault;
    logic [PFN_W-1:0]  e_pfn;

    logic [OFS_W-1:0]  vofs_q, uofs_q;
    logic [MODE_W-1:0] mode_q;
    logic              done_q, mreq_q;
    fault_e            fault_q;
    logic [PA_W-1:0]   paddr_q;
    logic [VA_W-1:0]   maddr_q;

    segpt_regs #(.N(NSEG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr && (state == ST_IDLE)),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .regs_o  (regs)
    );

    // first stage: region decode of the request itself
    segpt_segchk #(.N(NSEG)) u_vchk (
        .va_i        (req_vaddr),
        .regs_i      (regs),
        .seg_o       (v_seg),
        .in_bounds_o (v_inb),
        .user_o      (v_user),
        .ent_addr_o  (v_ent)
    );

    // nested stage: the user entry address is itself a system virtual address
    segpt_segchk #(.N(NSEG)) u_nchk (
        .va_i        (v_ent),
        .regs_i      (regs),
        .seg_o       (n_seg),
        .in_bounds_o (n_inb),
        .user_o      (n_user),
        .ent_addr_o  (n_ent)
    );

    segpt_pte_eval u_eval (
        .ent_i      (mem_rdata),
        .mode_i     (mode_q),
        .chk_prot_i (state == ST_WFIN),
        .fault_o    (e_fault),
        .pfn_o      (e_pfn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
            mreq_q  <= 1'b0;
            maddr_q <= '0;
            vofs_q  <= '0;
            uofs_q  <= '0;
            mode_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
            mreq_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vofs_q <= req_vaddr[OFS_W-1:0];
                        mode_q <= req_mode;
                        if (!v_inb) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_LEN;
                        end else if (!v_user) begin
                            mreq_q  <= 1'b1;
                            maddr_q <= v_ent;
                            state   <= ST_WFIN;
                        end else if (!n_inb || (n_seg != SEG_SYS) || n_user) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_LEN;
                        end else begin
                            mreq_q  <= 1'b1;
                            maddr_q <= n_ent;
                            uofs_q  <= v_ent[OFS_W-1:0];
                            state   <= ST_WSYS;
                        end
                    end
                end
                ST_WSYS: begin
                    if (mem_rvalid) begin
                        if (e_fault != FLT_NONE) begin
                            done_q  <= 1'b1;
                            fault_q <= e_fault;
                            state   <= ST_IDLE;
                        end else begin
                            mreq_q  <= 1'b1;
                            maddr_q <= {{(VA_W-PA_W){1'b0}}, e_pfn, uofs_q};
                            state   <= ST_WFIN;
                        end
                    end
                end
                ST_WFIN: begin
                    if (mem_rvalid) begin
                        done_q  <= 1'b1;
                        fault_q <= e_fault;
                        if (e_fault == FLT_NONE) paddr_q <= {e_pfn, vofs_q};
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_req  = mreq_q;
    assign mem_addr = maddr_q;
    assign done     = done_q;
    assign fault    = fault_q;
    assign paddr    = paddr_q;
endmodule

// File: rtl/segpt_walker_chk.sv
module segpt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        done,
    input logic [1:0]  fault,
    input logic [29:0] paddr
);
    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_read_in_walk_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_walk_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rvalid) |=> (busy && !done));

    assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> (paddr == 30'd0));

    assert_quiet_outside_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> (fault == 2'd0 && paddr == 30'd0));

    assert_idle_no_done_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> (!done && !busy));
endmodule

bind segpt_walker segpt_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fault      (fault),
    .paddr      (paddr)
);

// File: tb/segpt_walker_tb.sv
module segpt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_mode  = '0;
    logic        busy;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  fault;
    logic [29:0] paddr;

    segpt_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .busy(busy), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .fault(fault), .paddr(paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] m_base [4];
    logic [31:0] m_len  [4];
    logic [31:0] rdq [$];
    logic [31:0] exp_q [$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          inflight = 1'b0;
    bit          finished = 1'b0;
    int          rcnt = 0;
    logic [31:0] raddr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // memory responder and port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rcnt > 0) begin
            rcnt = rcnt - 1;
            if (rcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(raddr);
            end else begin
                mem_rvalid = 1'b0;
            end
        end else begin
            mem_rvalid = 1'b0;
        end
        if (!rst && mem_req) begin
            raddr = mem_addr;
            rcnt  = LAT;
            rdq.push_back(mem_addr);
        end
        if (!rst && done && !inflight)
            check(1'b0, "R11", "done without request", 64'(done), 64'd0);
    end

    task automatic ref_walk(input logic [31:0] va, input logic [1:0] md,
                            output logic [1:0] ef, output logic [29:0] epa);
        logic [1:0]  sg;
        logic [31:0] idx, pa, spa, pte, spte;
        exp_q.delete();
        ef = 2'd0; epa = '0;
        sg  = va[31:30];
        idx = {11'b0, va[29:9]};
        if (sg == 2'd3) begin ef = 2'd1; return; end
        if (idx >= m_len[sg]) begin ef = 2'd1; return; end
        pa = m_base[sg] + (idx << 2);
        if (sg != 2'd2) begin
            if (pa[31:30] != 2'd2 || {11'b0, pa[29:9]} >= m_len[2]) begin ef = 2'd1; return; end
            spa = m_base[2] + ({11'b0, pa[29:9]} << 2);
            exp_q.push_back(spa);
            spte = rd(spa);
            if (!spte[31]) begin ef = 2'd2; return; end
            pa = {2'b0, spte[20:0], pa[8:0]};
        end
        exp_q.push_back(pa);
        pte = rd(pa);
        if (!pte[31]) ef = 2'd2;
        else if (pte[30:27] > 4'd3 || {2'b0, md} > pte[30:27]) ef = 2'd3;
        else epa = {pte[20:0], va[8:0]};
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        if (sel[2:1] != 2'd3) begin
            if (sel[0]) m_len[sel[2:1]] = d; else m_base[sel[2:1]] = d;
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input logic [1:0] md,
                         input string rq, input bit disturb);
        logic [1:0]  ef;
        logic [29:0] epa;
        int          n;
        ref_walk(va, md, ef, epa);
        @(negedge clk);
        rdq.delete();
        req_valid = 1'b1; req_vaddr = va; req_mode = md; inflight = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 60) begin
            if (disturb && n == 1) begin
                req_valid = 1'b1; req_vaddr = 32'hC000_0000;
                reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'hDEAD_0000;
            end else begin
                req_valid = 1'b0; reg_wr = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0; reg_wr = 1'b0;
        check(done === 1'b1, rq, "done seen", 64'(done), 64'd1);
        check(fault == ef, rq, "fault code", 64'(fault), 64'(ef));
        check(paddr == epa, rq, "physical address", 64'(paddr), 64'(epa));
        check(n == 3 * exp_q.size(), rq, "latency", 64'(n), 64'(3 * exp_q.size()));
        check(rdq.size() == exp_q.size(), rq, "read count", 64'(rdq.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < rdq.size())
                check(rdq[i] == exp_q[i], rq, "read address", 64'(rdq[i]), 64'(exp_q[i]));
        end
        @(negedge clk);
        check(!done, "R11", "done width", 64'(done), 64'd0);
        inflight = 1'b0;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_len[i] = '0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs after reset
        check(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
        check(done == 1'b0, "R1", "done", 64'(done), 64'd0);
        check(mem_req == 1'b0, "R1", "mem_req", 64'(mem_req), 64'd0);
        check(fault == 2'd0 && paddr == 30'd0, "R1", "fault/paddr", 64'({fault, paddr}), 64'd0);
        xlate(32'h8000_0A10, 2'd0, "R1", 1'b0);

        // tables
        mem[32'h0001_0008] = 32'h8000_0300;   // system entry -> user A table frame
        mem[32'h0006_0004] = 32'h9800_1234;   // level 3
        mem[32'h0006_0008] = 32'h8400_0055;   // level 0, modify set
        mem[32'h0006_000C] = 32'hA800_0066;   // level 5
        mem[32'h0001_0014] = 32'h8FE0_0777;   // system page, level 1, sw bits set

        wr_reg(3'd4, 32'h0001_0000);
        wr_reg(3'd5, 32'd64);
        wr_reg(3'd0, 32'h8000_0400);
        wr_reg(3'd1, 32'd16);
        wr_reg(3'd2, 32'h8000_2000);
        wr_reg(3'd3, 32'd8);

        xlate(32'h8000_0A10, 2'd1, "R4", 1'b0);
        xlate(32'h8000_0A10, 2'd2, "R8", 1'b0);
        xlate(32'h0000_03AB, 2'd3, "R5", 1'b0);
        xlate(32'h0000_0000, 2'd0, "R7", 1'b0);
        xlate(32'h0000_0401, 2'd0, "R8", 1'b0);
        xlate(32'h0000_0401, 2'd1, "R8", 1'b0);
        xlate(32'h0000_0600, 2'd0, "R8", 1'b0);
        xlate(32'h0000_1E00, 2'd0, "R7", 1'b0);
        xlate(32'h0000_2000, 2'd0, "R3", 1'b0);
        xlate(32'h8000_8000, 2'd0, "R3", 1'b0);
        xlate(32'hC000_0000, 2'd0, "R2", 1'b0);
        xlate(32'h4000_0000, 2'd0, "R7", 1'b0);

        mem[32'h0001_0040] = 32'h8000_0400;
        mem[32'h0008_0000] = 32'h9000_0ABC;
        xlate(32'h4000_0123, 2'd2, "R5", 1'b0);
        xlate(32'h4000_0123, 2'd3, "R8", 1'b0);
        xlate(32'h4000_1000, 2'd0, "R3", 1'b0);

        // context switch: only user registers rewritten
        wr_reg(3'd0, 32'h0000_1000);
        xlate(32'h0000_03AB, 2'd0, "R6", 1'b0);
        wr_reg(3'd0, 32'h8000_8000);
        xlate(32'h0000_0000, 2'd0, "R6", 1'b0);
        xlate(32'h8000_0A10, 2'd0, "R10", 1'b0);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'h0000_0000);
        xlate(32'h8000_0A10, 2'd1, "R10", 1'b0);
        wr_reg(3'd0, 32'h8000_0400);

        // R9: request and register write during a walk have no effect
        xlate(32'h0000_03AB, 2'd3, "R9", 1'b1);
        repeat (4) @(negedge clk);
        xlate(32'h8000_0A10, 2'd1, "R9", 1'b0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule